// File: doc/BRIEF.md
# Two-Wire Controller Register Interface

This block is the register front end of a two-wire (I2C-style) serial controller. A CPU-style register bus writes and reads three byte-wide locations: a control register, a status register and a data register. The block keeps the software-visible state and passes requests to a bus-state engine through a small handshake. That state covers the enable, the interrupt enable, the event flag, the STOP request and the write-collision flag, along with the engine's status code and the bit-rate prescaler select. The bit-level SCL/SDA engine and the pin filters sit outside this block.

The engine raises `eng_event` when it needs software attention. This sets the event flag, and the flag drives the interrupt request whenever interrupts are enabled both locally and globally. A STOP request behaves differently by role. In master mode it stays pending until the engine answers with `stop_done`. In slave mode it produces a one-cycle recovery pulse, which returns the engine to the unaddressed state with both lines released. A data write is accepted only while the event flag is high. At any other time the write is refused and the collision is recorded.

Address map: 0 = control, 1 = status, 2 = data, 3 reads zero. Control register layout: bit 7 = event flag (write 1 to clear), bit 4 = STOP request, bit 3 = write collision (read-only), bit 2 = enable, bit 1 = reserved, bit 0 = interrupt enable, bits 6..5 read zero. Status register layout: bits 7..3 = status code (read-only), bit 2 = reserved, bits 1..0 = prescaler select.

Top module: `twc_regif`

## Requirements
- R1: A synchronous reset sets every control bit to 0, the data byte to 0x00, the status register to 0xF8, `irq` to 0 and `presc_div` to 1.
- R2: A control write that has bit 4 and bit 2 set while `eng_master`=1 raises `stop_cmd` on the next cycle. Control bit 4 then reads 1 until a `stop_done` pulse, and both return to 0 on the cycle after that pulse. A new STOP write in the same cycle as the pulse takes priority.
- R3: A control write that has bit 4 and bit 2 set while `eng_master`=0 gives a one-cycle `recover` pulse on the next cycle. It does not raise `stop_cmd`, it clears any pending STOP, and control bit 4 reads 0.
- R4: A data write made while the event flag is 0 sets the collision flag (control bit 3) and leaves the stored byte (`tx_byte`) unchanged.
- R5: A data write made while the event flag is 1 stores the byte, and `tx_byte` shows it on the next cycle. The write also clears the collision flag.
- R6: `eng_en` follows control bit 2 one cycle after the write. While it is 0, the STOP request and the event flag are held at 0, so any pending STOP is dropped.
- R7: `irq` is 1 exactly one cycle after a cycle in which event flag, control bit 0 and `gie` are all 1.
- R8: While enabled, an `eng_event` pulse sets the event flag (control bit 7). Writing 1 to bit 7 clears the flag, but a simultaneous event wins. Writing 0 to bit 7 has no effect.
- R9: While enabled, status bits 7..3 take on `eng_status` one cycle later. While disabled they hold their value. Writes never change them, and status bit 2 always reads 0.
- R10: Control bits 1, 5 and 6 always read 0, and the collision bit cannot be written.
- R11: Prescaler select 0, 1, 2, 3 (status bits 1..0, read/write) gives `presc_div` = 1, 4, 16, 64 one cycle after it is written.
- R12: `cpu_rdata` shows the register chosen by `cpu_addr` one cycle after the address is presented, taken from the register contents before any write in that same cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| gie | input | 1 | Global interrupt enable |
| eng_master | input | 1 | Engine reports master role |
| eng_event | input | 1 | Engine event pulse, sets the event flag |
| stop_done | input | 1 | Engine pulse: STOP placed on the bus |
| eng_status | input | 5 | Engine status code |
| eng_en | output | 1 | Interface enable to the engine |
| stop_cmd | output | 1 | Pending master STOP request |
| recover | output | 1 | One-cycle slave recovery pulse |
| tx_byte | output | 8 | Stored data byte |
| irq | output | 1 | Interrupt request |
| presc_div | output | 7 | Prescaler divide factor |

## Verification
Every write reaches its register one cycle after the write strobe, and `eng_en`, `stop_cmd`, `recover` and `tx_byte` follow at that same edge. The results computed from those registers (`irq`, `presc_div`, and `cpu_rdata` for the address presented) need one more cycle. The bench drives its inputs on the falling edge. A behavioural model steps once per rising edge, builds the registered outputs from its state before the update, and is compared with every output on the next falling edge. Directed sequences pin the master STOP handshake, the slave recovery pulse, refused and accepted data writes, and the four prescaler codes to fixed values at those same sample points.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int DW   = 8;
  localparam int AW   = 2;
  localparam int SW   = 5;
  localparam int PSW  = 2;
  localparam int DIVW = 2 * ((1 << PSW) - 1) + 1;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_DATA = 2'd2;

  localparam int B_FLAG = 7;
  localparam int B_STOP = 4;
  localparam int B_WCOL = 3;
  localparam int B_EN   = 2;
  localparam int B_IE   = 0;

  typedef struct packed {
    logic flag;
    logic stop;
    logic en;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/twc_ctrl.sv
module twc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic w_flag,
  input  logic w_stop,
  input  logic w_en,
  input  logic w_ie,
  input  logic eng_master,
  input  logic eng_event,
  input  logic stop_done,
  output twc_pkg::ctrl_t ctl,
  output logic recover
);
  logic en_nx;

  // enable as it stands after this cycle's write
  assign en_nx = wr ? w_en : ctl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      recover <= 1'b0;
    end else begin
      recover <= 1'b0;
      ctl.en  <= en_nx;
      if (wr) ctl.ie <= w_ie;

      if (!en_nx) begin
        ctl.stop <= 1'b0;
      end else if (wr && w_stop) begin
        if (eng_master) begin
          ctl.stop <= 1'b1;
        end else begin
          ctl.stop <= 1'b0;
          recover  <= 1'b1;
        end
      end else if (stop_done) begin
        ctl.stop <= 1'b0;
      end

      if (!en_nx) begin
        ctl.flag <= 1'b0;
      end else if (eng_event) begin
        ctl.flag <= 1'b1;
      end else if (wr && w_flag) begin
        ctl.flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twc_data.sv
module twc_data #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          flag,
  output logic [DW-1:0] data,
  output logic          wcol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      wcol <= 1'b0;
    end else if (wr) begin
      if (flag) begin
        data <= wdata;
        wcol <= 1'b0;
      end else begin
        wcol <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twc_stat.sv
module twc_stat #(
  parameter int SW  = 5,
  parameter int PSW = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [PSW-1:0]                wsel,
  input  logic                          en,
  input  logic [SW-1:0]                 eng_status,
  output logic [SW-1:0]                 code,
  output logic [PSW-1:0]                sel,
  output logic [2*((1<<PSW)-1):0]       div
);
  localparam int DIVW = 2 * ((1 << PSW) - 1) + 1;
  localparam int NSEL = 1 << PSW;

  logic [DIVW-1:0] div_nx;

  // one-hot factor 4**sel, one select per generated term
  for (genvar k = 0; k < NSEL; k++) begin : g_div
    assign div_nx[2*k] = (sel == PSW'(k));
    if (k < NSEL - 1) begin : g_gap
      assign div_nx[2*k+1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '1;
      sel  <= '0;
      div  <= DIVW'(1);
    end else begin
      if (en) code <= eng_status;
      if (wr) sel <= wsel;
      div <= div_nx;
    end
  end
endmodule

// File: rtl/twc_regif.sv
module twc_regif #(
  parameter int DW  = twc_pkg::DW,
  parameter int SW  = twc_pkg::SW,
  parameter int PSW = twc_pkg::PSW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_we,
  input  logic [1:0]              cpu_addr,
  input  logic [DW-1:0]           cpu_wdata,
  output logic [DW-1:0]           cpu_rdata,
  input  logic                    gie,
  input  logic                    eng_master,
  input  logic                    eng_event,
  input  logic                    stop_done,
  input  logic [SW-1:0]           eng_status,
  output logic                    eng_en,
  output logic                    stop_cmd,
  output logic                    recover,
  output logic [DW-1:0]           tx_byte,
  output logic                    irq,
  output logic [2*((1<<PSW)-1):0] presc_div
);
  import twc_pkg::*;

  twc_pkg::ctrl_t   ctl;
  logic             wcol_q;
  logic [SW-1:0]    code_q;
  logic [PSW-1:0]   sel_q;
  logic             wr_ctrl, wr_stat, wr_data;
  logic [DW-1:0]    ctrl_view, stat_view, rd_nx;

  assign wr_ctrl = cpu_we && (cpu_addr == A_CTRL);
  assign wr_stat = cpu_we && (cpu_addr == A_STAT);
  assign wr_data = cpu_we && (cpu_addr == A_DATA);

  twc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctrl),
    .w_flag(cpu_wdata[B_FLAG]), .w_stop(cpu_wdata[B_STOP]),
    .w_en(cpu_wdata[B_EN]), .w_ie(cpu_wdata[B_IE]),
    .eng_master(eng_master), .eng_event(eng_event), .stop_done(stop_done),
    .ctl(ctl), .recover(recover)
  );

  twc_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .wr(wr_data), .wdata(cpu_wdata),
    .flag(ctl.flag), .data(tx_byte), .wcol(wcol_q)
  );

  twc_stat #(.SW(SW), .PSW(PSW)) u_stat (
    .clk(clk), .rst(rst), .wr(wr_stat), .wsel(cpu_wdata[PSW-1:0]),
    .en(ctl.en), .eng_status(eng_status),
    .code(code_q), .sel(sel_q), .div(presc_div)
  );

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_FLAG] = ctl.flag;
    ctrl_view[B_STOP] = ctl.stop;
    ctrl_view[B_WCOL] = wcol_q;
    ctrl_view[B_EN]   = ctl.en;
    ctrl_view[B_IE]   = ctl.ie;
    stat_view         = {code_q, 1'b0, sel_q};
    case (cpu_addr)
      A_CTRL:  rd_nx = ctrl_view;
      A_STAT:  rd_nx = stat_view;
      A_DATA:  rd_nx = tx_byte;
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      cpu_rdata <= rd_nx;
      irq       <= ctl.flag && ctl.ie && gie;
    end
  end

  assign eng_en   = ctl.en;
  assign stop_cmd = ctl.stop;
endmodule

// File: rtl/twc_regif_chk.sv
module twc_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_we,
  input logic [1:0] cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic       gie,
  input logic       stop_done,
  input logic       eng_en,
  input logic       stop_cmd,
  input logic       recover,
  input logic [7:0] tx_byte,
  input logic       irq,
  input logic [6:0] presc_div,
  input logic       flag,
  input logic       ie,
  input logic       wcol
);
  assert_stop_done_R2: assert property (@(posedge clk) disable iff (rst)
    stop_done && !(cpu_we && cpu_addr == 2'd0 && cpu_wdata[4]) |=> !stop_cmd);

  assert_slave_recover_R3: assert property (@(posedge clk) disable iff (rst)
    recover |-> !stop_cmd);

  assert_wcol_set_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_we && cpu_addr == 2'd2 && !flag |=> wcol && $stable(tx_byte));

  assert_wcol_clear_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_we && cpu_addr == 2'd2 && flag |=> !wcol && tx_byte == $past(cpu_wdata));

  assert_off_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !eng_en |-> !stop_cmd && !flag);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && ie && gie));

  assert_div_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(presc_div) == 1);
endmodule

bind twc_regif twc_regif_chk u_chk (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .gie(gie), .stop_done(stop_done),
  .eng_en(eng_en), .stop_cmd(stop_cmd), .recover(recover),
  .tx_byte(tx_byte), .irq(irq), .presc_div(presc_div),
  .flag(ctl.flag), .ie(ctl.ie), .wcol(wcol_q)
);

// File: tb/twc_regif_test.sv
`timescale 1ns/1ps
module twc_regif_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_we = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       gie = 1'b0, eng_master = 1'b1, eng_event = 1'b0, stop_done = 1'b0;
  logic [4:0] eng_status = 5'd0;
  logic       eng_en, stop_cmd, recover, irq;
  logic [7:0] tx_byte;
  logic [6:0] presc_div;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit       m_valid = 0;
  bit       m_en, m_ie, m_flag, m_stop, m_rec, m_wcol, m_irq;
  int       m_data, m_code, m_sel, m_rd, m_div, m_rd_addr;

  always #2.5 clk = ~clk;

  twc_regif uut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .gie(gie),
    .eng_master(eng_master), .eng_event(eng_event), .stop_done(stop_done),
    .eng_status(eng_status), .eng_en(eng_en), .stop_cmd(stop_cmd),
    .recover(recover), .tx_byte(tx_byte), .irq(irq), .presc_div(presc_div)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ctrl_word();
    return (int'(m_flag) << 7) | (int'(m_stop) << 4) | (int'(m_wcol) << 3) |
           (int'(m_en) << 2) | int'(m_ie);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 1; m_en = 0; m_ie = 0; m_flag = 0; m_stop = 0; m_rec = 0;
      m_wcol = 0; m_irq = 0; m_data = 0; m_code = 31; m_sel = 0; m_rd = 0;
      m_div = 1; m_rd_addr = 0;
    end else begin
      bit wc, en_n;
      case (cpu_addr)
        2'd0: m_rd = ctrl_word();
        2'd1: m_rd = (m_code << 3) | m_sel;
        2'd2: m_rd = m_data;
        default: m_rd = 0;
      endcase
      m_rd_addr = cpu_addr;
      m_irq = m_flag && m_ie && gie;
      m_div = 1 << (2 * m_sel);
      wc = cpu_we && cpu_addr == 2'd0;
      en_n = wc ? cpu_wdata[2] : m_en;
      m_rec = 0;
      if (!en_n) m_stop = 0;
      else if (wc && cpu_wdata[4]) begin
        if (eng_master) m_stop = 1; else begin m_stop = 0; m_rec = 1; end
      end else if (stop_done) m_stop = 0;
      if (!en_n) m_flag_upd(0);
      else if (eng_event) m_flag_upd(1);
      else if (wc && cpu_wdata[7]) m_flag_upd(0);
      else m_flag_upd(m_flag);
      if (m_en) m_code = eng_status;
      if (cpu_we && cpu_addr == 2'd1) m_sel = cpu_wdata[1:0];
      if (cpu_we && cpu_addr == 2'd2) begin
        if (m_flag_old) begin m_data = cpu_wdata; m_wcol = 0; end
        else m_wcol = 1;
      end
      if (wc) m_ie = cpu_wdata[0];
      m_en = en_n;
      m_flag = m_flag_new;
    end
  end

  // flag update staged so the data rule sees the old flag
  bit m_flag_old, m_flag_new;
  always @(negedge clk) m_flag_old = m_flag;
  function automatic void m_flag_upd(input bit v);
    m_flag_new = v;
  endfunction

  always @(negedge clk) begin
    if (m_valid && !rst && !done) begin
      chk("R6 eng_en", eng_en, m_en);
      chk("R2 stop_cmd", stop_cmd, m_stop);
      chk("R3 recover", recover, m_rec);
      chk("R7 irq", irq, m_irq);
      chk("R11 presc_div", presc_div, m_div);
      chk("R5 tx_byte", tx_byte, m_data);
      case (m_rd_addr)
        0: chk("R12 R8 R10 ctrl readback", cpu_rdata, m_rd);
        1: chk("R12 R9 status readback", cpu_rdata, m_rd);
        default: chk("R12 R4 data readback", cpu_rdata, m_rd);
      endcase
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    cyc();
    cpu_we = 0;
  endtask

  task automatic rd_check(input logic [1:0] a, input string tag, input int exp);
    cpu_addr = a;
    cyc();
    chk(tag, cpu_rdata, exp);
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 presc_div", presc_div, 1);
    chk("R1 tx_byte", tx_byte, 0);
    rd_check(2'd0, "R1 ctrl", 8'h00);
    rd_check(2'd1, "R1 status", 8'hF8);
    // R4 refused write with flag low
    wr(2'd0, 8'h05);
    wr(2'd2, 8'hA5);
    chk("R4 tx_byte kept", tx_byte, 8'h00);
    rd_check(2'd0, "R4 wcol set", 8'h0D);
    // R8 event, R7 irq
    gie = 1;
    eng_event = 1; cyc(); eng_event = 0;
    cyc();
    chk("R7 irq raised", irq, 1);
    // R5 accepted write
    wr(2'd2, 8'h3C);
    chk("R5 tx_byte", tx_byte, 8'h3C);
    rd_check(2'd0, "R5 wcol clear", 8'h85);
    // R8 clear by writing one
    wr(2'd0, 8'h85);
    rd_check(2'd0, "R8 flag cleared", 8'h05);
    // R2 master stop
    eng_master = 1;
    wr(2'd0, 8'h14);
    chk("R2 stop raised", stop_cmd, 1);
    cyc(); cyc();
    chk("R2 stop held", stop_cmd, 1);
    stop_done = 1; cyc(); stop_done = 0;
    chk("R2 stop cleared", stop_cmd, 0);
    // R3 slave recovery
    eng_master = 0;
    wr(2'd0, 8'h14);
    chk("R3 recover pulse", recover, 1);
    chk("R3 no stop", stop_cmd, 0);
    cyc();
    chk("R3 pulse ends", recover, 0);
    // R11 prescaler codes
    for (int s = 0; s < 4; s++) begin
      wr(2'd1, 8'(s) | 8'hF8);
      cyc();
      chk("R11 divide", presc_div, 1 << (2 * s));
    end
    // R9 status code tracking
    eng_status = 5'h0A; cyc(); cyc();
    rd_check(2'd1, "R9 status code", (8'h0A << 3) | 3);
    // R6 disable freezes status
    wr(2'd0, 8'h00);
    chk("R6 eng_en off", eng_en, 0);
    eng_status = 5'h15; cyc(); cyc();
    rd_check(2'd1, "R9 status frozen", (8'h0A << 3) | 3);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      cpu_we     = ($urandom_range(0, 9) < 3);
      cpu_addr   = 2'($urandom_range(0, 3));
      cpu_wdata  = 8'($urandom);
      if (cpu_addr == 2'd0 && $urandom_range(0, 9) < 8) cpu_wdata[2] = 1'b1;
      gie        = ($urandom_range(0, 3) != 0);
      eng_master = ($urandom_range(0, 3) != 0);
      eng_event  = ($urandom_range(0, 9) == 0);
      stop_done  = ($urandom_range(0, 9) == 0);
      eng_status = 5'($urandom);
      cyc();
    end
    cpu_we = 0; eng_event = 0; stop_done = 0;
    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule